// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the timing of a video raster for an output port. Six programmable counts shape the raster: clocks per line, first and last active pixel, lines per field, and first and last active line. Any raster from 1 to 4095 in either direction is supported. The block drives two gate pins. The horizontal gate marks active pixels. The vertical gate marks active lines over their whole length.

The block can also place four-byte timing codes into an 8-bit byte stream. One code marks the start of active video and another marks its end, and each carries computed protection bits. A multiplexer chooses, on each clock, between the incoming pixel byte and a code byte. The gate pins and the embedded codes have separate enables, so either or both can be on. A field flag toggles from field to field when interlace is selected.

Configuration inputs are captured into shadow registers only when a field begins. This allows software to change them at any time without tearing a field. A clock enable advances the raster; while it is low, all state holds.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is asserted, and until the first clock edge with `en` high after reset, `hgate`, `vgate`, `field` and `dout_is_code` are 0 and `dout` equals `pix_in`.
- R2: The first enabled edge after reset captures the configuration and puts the raster at pixel 0 of line 0. Each later enabled edge advances the pixel. When the pixel reaches `cfg_line_len`-1, it returns to 0 and the line advances. When the line reaches `cfg_field_len`-1 as well, a new field starts at line 0.
- R3: `hgate` is 1 exactly when gates are enabled, the pixel lies in [`cfg_hact_first`, `cfg_hact_last`], and the line lies in [`cfg_vact_first`, `cfg_vact_last`].
- R4: `vgate` is 1 exactly when gates are enabled and the line lies in the active line range, for every pixel of that line. `hgate` implies `vgate`.
- R5: When codes are enabled, the four pixels `cfg_hact_first`-4 to `cfg_hact_first`-1 of every line carry `dout` = FF, 00, 00, XY in that order, with H=0 and `dout_is_code`=1. Slots that would fall before pixel 0 are dropped.
- R6: When codes are enabled, pixels `cfg_hact_last`+1 to `cfg_hact_last`+4 of every line carry FF, 00, 00, XY with H=1 and `dout_is_code`=1. This applies to blanking lines too.
- R7: The XY byte holds these bits. Bit 7 is 1. Bit 6 is F (the field flag). Bit 5 is V, which is 1 on lines outside the active range. Bit 4 is H. Bits 3 down to 0 are V^H, F^H, F^V and F^V^H.
- R8: `field` is 0 in the first field after reset. At each field start it inverts if the newly captured interlace bit is 1, and becomes 0 otherwise.
- R9: A change of any configuration input during a field has no effect on any output until the next field starts.
- R10: While `en` is 0, the raster position, field flag, gates and code slots hold their values.
- R11: With codes disabled, `dout_is_code` is 0 and `dout` equals `pix_in`. With gates disabled, both gates are 0. Outside code slots, `dout` always equals `pix_in`.
- R12: Line lengths and field lengths at both extremes, 1 and 4095, give the raster described in R2 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Clock enable for the raster |
| cfg_line_len | input | 12 | Clocks per line (1..4095) |
| cfg_hact_first | input | 12 | First active pixel |
| cfg_hact_last | input | 12 | Last active pixel |
| cfg_field_len | input | 12 | Lines per field (1..4095) |
| cfg_vact_first | input | 12 | First active line |
| cfg_vact_last | input | 12 | Last active line |
| cfg_interlace | input | 1 | Toggle the field flag each field |
| cfg_gate_en | input | 1 | Enable the gate pins |
| cfg_code_en | input | 1 | Enable embedded timing codes |
| pix_in | input | 8 | Pixel byte to pass through |
| hgate | output | 1 | Horizontal gate, high on active pixels |
| vgate | output | 1 | Vertical gate, high on active lines |
| field | output | 1 | Field flag |
| dout | output | 8 | Output byte stream |
| dout_is_code | output | 1 | Current byte is a timing-code byte |

## Verification
The bench sweeps whole fields of several small rasters. It computes each expected output from the cycle index by division and remainder, so an off-by-one wrap shifts every later sample and is caught at once. A configuration change in the middle of a field must leave that field untouched; a design that applied it immediately would shorten the line at that point. The bench also covers a one-clock line and a one-line field, where the field flag inverts on every clock, and a 4095-clock line, where a counter that is too narrow or an end-code window that wraps would misplace the end code. A swapped or missing term in the protection bits shows up in the XY bytes checked across both field parities and across blanking and active lines.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int RT_CW       = 12;
  localparam int RT_CODE_LEN = 4;
  localparam logic [7:0] RT_PREAMBLE_HI = 8'hFF;
  localparam logic [7:0] RT_PREAMBLE_LO = 8'h00;

  // status byte of a timing code: marker, flags, then protection bits
  function automatic logic [7:0] rt_xy_byte(input logic f, input logic v, input logic h);
    rt_xy_byte = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/rt_rst_sync.sv
module rt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int CW = 12,
  localparam int SHW = 6 * CW + 3
) (
  input  logic           clk,
  input  logic           rst_s,
  input  logic           en,
  input  logic [SHW-1:0] cfg_vec,
  input  logic           cfg_interlace,
  output logic [CW-1:0]  h_cnt,
  output logic [CW-1:0]  v_cnt,
  output logic           fld_q,
  output logic           primed,
  output logic [SHW-1:0] sh_vec
);
  logic [CW-1:0]  h_n, v_n;
  logic           fld_n, primed_n, load;
  logic [CW-1:0]  sh_len, sh_lines;

  assign sh_len   = sh_vec[SHW-1 -: CW];
  assign sh_lines = sh_vec[SHW-1-3*CW -: CW];

  always_comb begin
    h_n      = h_cnt;
    v_n      = v_cnt;
    fld_n    = fld_q;
    primed_n = primed;
    load     = 1'b0;
    if (en) begin
      if (!primed) begin
        load     = 1'b1;
        h_n      = '0;
        v_n      = '0;
        fld_n    = 1'b0;
        primed_n = 1'b1;
      end else if (h_cnt == sh_len - 1'b1) begin
        h_n = '0;
        if (v_cnt == sh_lines - 1'b1) begin
          v_n   = '0;
          load  = 1'b1;
          fld_n = cfg_interlace ? ~fld_q : 1'b0;
        end else begin
          v_n = v_cnt + 1'b1;
        end
      end else begin
        h_n = h_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      h_cnt  <= '0;
      v_cnt  <= '0;
      fld_q  <= 1'b0;
      primed <= 1'b0;
    end else if (en) begin
      h_cnt  <= h_n;
      v_cnt  <= v_n;
      fld_q  <= fld_n;
      primed <= primed_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)    sh_vec <= '0;
    else if (load) sh_vec <= cfg_vec;
  end
endmodule

// File: rtl/rt_decode.sv
module rt_decode #(
  parameter int CW = 12,
  localparam int XW = CW + 1
) (
  input  logic          primed,
  input  logic [CW-1:0] h_cnt,
  input  logic [CW-1:0] v_cnt,
  input  logic [CW-1:0] hs,
  input  logic [CW-1:0] he,
  input  logic [CW-1:0] vs,
  input  logic [CW-1:0] ve,
  input  logic          gate_en,
  input  logic          code_en,
  output logic          hgate,
  output logic          vgate,
  output logic          vblank,
  output logic          code_act,
  output logic          code_h,
  output logic [1:0]    code_idx
);
  localparam logic [XW-1:0] SLOTS = XW'(raster_pkg::RT_CODE_LEN);

  logic          in_h, in_v, sav, eav;
  logic [XW-1:0] h_x, hs_x, he_x;

  assign h_x  = {1'b0, h_cnt};
  assign hs_x = {1'b0, hs};
  assign he_x = {1'b0, he};

  assign in_h = (h_cnt >= hs) && (h_cnt <= he);
  assign in_v = (v_cnt >= vs) && (v_cnt <= ve);

  assign hgate  = primed && gate_en && in_h && in_v;
  assign vgate  = primed && gate_en && in_v;
  assign vblank = !in_v;

  assign sav = primed && code_en && (h_x + SLOTS >= hs_x) && (h_cnt < hs);
  assign eav = primed && code_en && !sav && (h_cnt > he) && (h_x <= he_x + SLOTS);

  assign code_act = sav || eav;
  assign code_h   = eav;
  assign code_idx = sav ? (h_cnt[1:0] - hs[1:0]) : (h_cnt[1:0] - he[1:0] - 2'd1);
endmodule

// File: rtl/rt_code_mux.sv
module rt_code_mux (
  input  logic       code_act,
  input  logic       code_h,
  input  logic [1:0] code_idx,
  input  logic       fld,
  input  logic       vblank,
  input  logic [7:0] pix_in,
  output logic [7:0] dout,
  output logic       dout_is_code
);
  logic [7:0] code_byte;

  always_comb begin
    unique case (code_idx)
      2'd0:    code_byte = raster_pkg::RT_PREAMBLE_HI;
      2'd3:    code_byte = raster_pkg::rt_xy_byte(fld, vblank, code_h);
      default: code_byte = raster_pkg::RT_PREAMBLE_LO;
    endcase
  end

  assign dout         = code_act ? code_byte : pix_in;
  assign dout_is_code = code_act;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CW = raster_pkg::RT_CW,
  localparam int SHW = 6 * CW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cfg_line_len,
  input  logic [CW-1:0] cfg_hact_first,
  input  logic [CW-1:0] cfg_hact_last,
  input  logic [CW-1:0] cfg_field_len,
  input  logic [CW-1:0] cfg_vact_first,
  input  logic [CW-1:0] cfg_vact_last,
  input  logic          cfg_interlace,
  input  logic          cfg_gate_en,
  input  logic          cfg_code_en,
  input  logic [7:0]    pix_in,
  output logic          hgate,
  output logic          vgate,
  output logic          field,
  output logic [7:0]    dout,
  output logic          dout_is_code
);
  logic           rst_s, primed, fld_q;
  logic [CW-1:0]  h_cnt, v_cnt;
  logic [SHW-1:0] sh_vec;
  logic [CW-1:0]  sh_len, sh_hs, sh_he, sh_lines, sh_vs, sh_ve;
  logic           sh_il, sh_gate, sh_code;
  logic           vblank, code_act, code_h;
  logic [1:0]     code_idx;

  rt_rst_sync #(.STAGES(2)) rst_i (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  rt_counter #(.CW(CW)) cnt_i (
    .clk(clk), .rst_s(rst_s), .en(en),
    .cfg_vec({cfg_line_len, cfg_hact_first, cfg_hact_last, cfg_field_len,
              cfg_vact_first, cfg_vact_last, cfg_interlace, cfg_gate_en, cfg_code_en}),
    .cfg_interlace(cfg_interlace),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .fld_q(fld_q), .primed(primed), .sh_vec(sh_vec)
  );

  assign {sh_len, sh_hs, sh_he, sh_lines, sh_vs, sh_ve, sh_il, sh_gate, sh_code} = sh_vec;

  rt_decode #(.CW(CW)) dec_i (
    .primed(primed), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .hs(sh_hs), .he(sh_he), .vs(sh_vs), .ve(sh_ve),
    .gate_en(sh_gate), .code_en(sh_code),
    .hgate(hgate), .vgate(vgate), .vblank(vblank),
    .code_act(code_act), .code_h(code_h), .code_idx(code_idx)
  );

  rt_code_mux mux_i (
    .code_act(code_act), .code_h(code_h), .code_idx(code_idx),
    .fld(fld_q), .vblank(vblank), .pix_in(pix_in),
    .dout(dout), .dout_is_code(dout_is_code)
  );

  assign field = fld_q;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int CW = 12,
  localparam int SHW = 6 * CW + 3
) (
  input logic           clk,
  input logic           rst_s,
  input logic           en,
  input logic           primed,
  input logic [CW-1:0]  h_cnt,
  input logic [CW-1:0]  v_cnt,
  input logic           fld_q,
  input logic [CW-1:0]  sh_len,
  input logic [CW-1:0]  sh_lines,
  input logic           sh_il,
  input logic [SHW-1:0] sh_vec,
  input logic           hgate,
  input logic           vgate,
  input logic           dout_is_code,
  input logic [7:0]     dout,
  input logic [7:0]     pix_in
);
  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_s)
    primed |-> (h_cnt < sh_len) && (v_cnt < sh_lines));

  p_hgate_in_vgate_r4: assert property (@(posedge clk) disable iff (!rst_s)
    hgate |-> vgate);

  p_code_outside_active_r5: assert property (@(posedge clk) disable iff (!rst_s)
    dout_is_code |-> !hgate);

  p_field_flat_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !sh_il |-> !fld_q);

  p_shadow_at_start_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (h_cnt != '0 || v_cnt != '0) |-> $stable(sh_vec));

  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (primed && !en) |=> $stable(h_cnt) && $stable(v_cnt) && $stable(fld_q));

  p_passthrough_r11: assert property (@(posedge clk) disable iff (!rst_s)
    !dout_is_code |-> dout == pix_in);
endmodule

bind raster_timing_gen rt_checker #(.CW(CW)) chk_i (
  .clk(clk), .rst_s(rst_s), .en(en), .primed(primed),
  .h_cnt(h_cnt), .v_cnt(v_cnt), .fld_q(fld_q),
  .sh_len(sh_len), .sh_lines(sh_lines), .sh_il(sh_il), .sh_vec(sh_vec),
  .hgate(hgate), .vgate(vgate), .dout_is_code(dout_is_code),
  .dout(dout), .pix_in(pix_in)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
  typedef struct {
    int len, hs, he, lines, vs, ve;
    bit il, g, c;
  } tcfg_t;

  logic        clk, rst_n, en;
  logic [11:0] cfg_line_len, cfg_hact_first, cfg_hact_last;
  logic [11:0] cfg_field_len, cfg_vact_first, cfg_vact_last;
  logic        cfg_interlace, cfg_gate_en, cfg_code_en;
  logic [7:0]  pix_in, dout;
  logic        hgate, vgate, field, dout_is_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  raster_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_line_len(cfg_line_len), .cfg_hact_first(cfg_hact_first), .cfg_hact_last(cfg_hact_last),
    .cfg_field_len(cfg_field_len), .cfg_vact_first(cfg_vact_first), .cfg_vact_last(cfg_vact_last),
    .cfg_interlace(cfg_interlace), .cfg_gate_en(cfg_gate_en), .cfg_code_en(cfg_code_en),
    .pix_in(pix_in), .hgate(hgate), .vgate(vgate), .field(field),
    .dout(dout), .dout_is_code(dout_is_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic apply(input tcfg_t c);
    cfg_line_len   = 12'(c.len);
    cfg_hact_first = 12'(c.hs);
    cfg_hact_last  = 12'(c.he);
    cfg_field_len  = 12'(c.lines);
    cfg_vact_first = 12'(c.vs);
    cfg_vact_last  = 12'(c.ve);
    cfg_interlace  = c.il;
    cfg_gate_en    = c.g;
    cfg_code_en    = c.c;
  endtask

  // compare outputs against the raster computed from the position index
  task automatic expect_state(input tcfg_t c, input int kk, input bit f,
                              input string tag_over);
    int h, v, idx;
    bit va, ha, eh, ev, sav, eav, hb, vb, ec;
    logic [7:0] eb;
    string tg, tv, tc;
    h  = kk % c.len;
    v  = kk / c.len;
    va = (v >= c.vs) && (v <= c.ve);
    ha = (h >= c.hs) && (h <= c.he);
    eh = c.g && va && ha;
    ev = c.g && va;
    vb = !va;
    sav = c.c && (h + 4 >= c.hs) && (h < c.hs);
    eav = c.c && !sav && (h > c.he) && (h <= c.he + 4);
    ec  = sav || eav;
    hb  = eav;
    idx = sav ? (h + 4 - c.hs) : (h - c.he - 1);
    eb  = pix_in;
    if (ec) begin
      if (idx == 0)      eb = 8'hFF;
      else if (idx == 3) eb = {1'b1, f, vb, hb, vb ^ hb, f ^ hb, f ^ vb, f ^ vb ^ hb};
      else               eb = 8'h00;
    end
    tg = !c.g ? "R11" : (h == 0 && kk > 0) ? "R2" : "R3";
    tv = !c.g ? "R11" : "R4";
    tc = !c.c ? "R11" : !ec ? "R11" : (idx == 3) ? "R7" : sav ? "R5" : "R6";
    if (tag_over != "") begin tg = tag_over; tv = tag_over; tc = tag_over; end
    check(hgate == eh, tg, "hgate", int'(hgate), int'(eh));
    check(vgate == ev, tv, "vgate", int'(vgate), int'(ev));
    check(field == f, (tag_over != "") ? tag_over : "R8", "field", int'(field), int'(f));
    check(dout_is_code == ec, tc, "dout_is_code", int'(dout_is_code), int'(ec));
    check(dout == eb, tc, "dout", int'(dout), int'(eb));
  endtask

  task automatic run(input tcfg_t a, input tcfg_t b, input int chg, input int frz,
                     input int total, input string tag_over);
    tcfg_t cur, pins;
    int kk;
    bit f;
    string tg;
    pins = a;
    apply(a);
    en = 1'b0;
    pix_in = 8'h3C;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!hgate && !vgate && !field && !dout_is_code && dout == pix_in, "R1",
          "outputs in reset", {hgate, vgate, field, dout_is_code}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pix_in = 8'hC3;
    #1;
    check(!hgate && !vgate && !field && !dout_is_code, "R1",
          "outputs before first enable", {hgate, vgate, field, dout_is_code}, 0);
    check(dout == pix_in, "R1", "dout before first enable", int'(dout), int'(pix_in));
    en = 1'b1;
    cur = pins;
    kk = 0;
    f = 1'b0;
    for (int it = 0; it < total; it++) begin
      @(negedge clk);
      pix_in = 8'(it * 37 + 11);
      #1;
      tg = tag_over;
      if (tg == "" && it > frz && it <= frz + 3) tg = "R10";
      if (tg == "" && pins.len != cur.len) tg = "R9";
      expect_state(cur, kk, f, tg);
      if (it == chg) begin pins = b; apply(b); end
      if (it >= frz && it < frz + 3) begin
        en = 1'b0;
      end else begin
        en = 1'b1;
        kk++;
        if (kk == cur.len * cur.lines) begin
          kk  = 0;
          cur = pins;
          f   = pins.il ? ~f : 1'b0;
        end
      end
    end
    en = 1'b0;
  endtask

  initial begin
    tcfg_t ca, cb, cc, cd, ce, cf;
    ca = '{12, 5, 7, 6, 2, 4, 1'b1, 1'b1, 1'b1};
    cb = '{9, 4, 5, 4, 1, 2, 1'b0, 1'b1, 1'b1};
    cc = '{8, 4, 6, 3, 0, 1, 1'b1, 1'b1, 1'b0};
    cd = '{8, 4, 6, 3, 0, 1, 1'b1, 1'b0, 1'b1};
    ce = '{1, 0, 0, 1, 0, 0, 1'b1, 1'b1, 1'b1};
    cf = '{4095, 4, 4090, 2, 1, 1, 1'b1, 1'b1, 1'b1};
    rst_n = 1'b0;
    en = 1'b0;
    apply(ca);
    pix_in = 8'h00;
    // field change mid-way, then an idle window
    run(ca, cb, 40, 100, 260, "");
    // codes off, gates on
    run(cc, cc, -1, -10, 80, "");
    // gates off, codes on
    run(cd, cd, -1, -10, 80, "");
    // one-clock line, one-line field
    run(ce, ce, -1, -10, 20, "R12");
    // longest line
    run(cf, cf, -1, -10, 3 * 8190 + 5, "R12");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(150000 * 20);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule